// File: doc/BRIEF.md
# SPI Register Access Port

This block is a serial target that lets an external host read and write a bank of 64 registers, each 24 bits wide. The host exchanges fixed 32-bit frames while it holds an active-high select. The serial clock idles low. Both sides sample on the rising edge and change data on the falling edge. The most significant bit of a frame travels first.

The top bit of a frame chooses between write (1) and read (0). The next six bits name the register. Bit 24 is not used. The low 24 bits carry the write value on the way in, and the read value on the way out. A write reaches the register bus only when the select drops after exactly 32 serial clocks. A frame of any other length is dropped.

A read is issued as soon as the seven header bits have arrived. The register bank answers in the system clock cycle after the read strobe, and its answer is shifted out in the low 24 bits of the same frame. The three serial pins pass through two-flop synchronizers into the system clock domain. Each serial clock phase must therefore last at least four system clock cycles.

Top module: `spi_regport`

## Requirements
- R1: MOSI is sampled on rising serial clock edges while the select is high, most significant bit first.
- R2: Frame bit 31 is the write flag (1 = write, 0 = read). Bits 30:25 are the register address and are presented on `reg_addr`. Bit 24 is ignored.
- R3: A write frame of exactly 32 serial clocks produces exactly one `reg_we` pulse after the select falls, carrying the frame's address and its bits 23:0 on `reg_wdata`. `reg_we` and `reg_re` are never high together.
- R4: A write frame that ends after any number of serial clocks other than 32 produces no `reg_we`, and the register bank is left unchanged.
- R5: A read frame produces exactly one single-cycle `reg_re` pulse once its seven header bits are received. The bank must drive `reg_rdata` in the cycle after `reg_re`.
- R6: During a 32-bit read frame, MISO bits 23:0 carry the addressed register's value, most significant bit first, changed on falling serial clock edges.
- R7: MISO is 0 for frame bits 31:24 of a read, for the whole of a write frame, and whenever the select is low.
- R8: Serial clock pulses while the select is low cause no strobe and do not disturb the next frame.
- R9: After reset, `reg_we`, `reg_re` and `spi_miso` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_sclk | input | 1 | Serial clock from host, idles low |
| spi_cs | input | 1 | Frame select, active high |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| reg_addr | output | ADDR_W (6) | Register address of the current or last frame |
| reg_wdata | output | DATA_W (24) | Write value |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read strobe |
| reg_rdata | input | DATA_W (24) | Read value from the bank, valid the cycle after `reg_re` |

## Verification
The bench builds the block with its defaults: a 6-bit address and 24-bit data. This makes the whole 64-entry space reachable, including the end addresses 0 and 63 and the all-ones data value. The bench keeps its own register bank and its own expected bank. It drives frames of 5, 31, 32 and 33 bits, so both the read-header threshold and the exact-length write rule are crossed from each side. On every clock it checks that the two strobes never coincide and that MISO is quiet while the select is low.

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int HDR_W   = ADDR_W + 1;
  localparam int FRAME_W = HDR_W + 1 + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] TX_FIRST = CNT_W'(HDR_W + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);

  logic [2:0] sclk_p, cs_p;
  logic [1:0] mosi_p;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] rx_sh, tx_sh;
  logic is_wr, cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_p <= '0;
      cs_p   <= '0;
      mosi_p <= '0;
    end else begin
      sclk_p <= {sclk_p[1:0], spi_sclk};
      cs_p   <= {cs_p[1:0], spi_cs};
      mosi_p <= {mosi_p[0], spi_mosi};
    end
  end

  wire cs_s   = cs_p[1];
  wire cs_q   = cs_p[2];
  wire mosi_s = mosi_p[1];
  wire rise   = cs_s & sclk_p[1] & ~sclk_p[2];
  wire fall   = cs_s & ~sclk_p[1] & sclk_p[2];
  wire start  = cs_s & ~cs_q;
  wire stop   = ~cs_s & cs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      is_wr     <= 1'b0;
      cap       <= 1'b0;
      spi_miso  <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      reg_re <= 1'b0;
      cap    <= reg_re;
      if (cap) tx_sh <= reg_rdata;
      if (start) begin
        cnt      <= '0;
        is_wr    <= 1'b0;
        spi_miso <= 1'b0;
      end else if (!cs_s) begin
        spi_miso <= 1'b0;
      end
      if (rise) begin
        rx_sh <= {rx_sh[DATA_W-2:0], mosi_s};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        if (cnt == HDR_LAST) begin
          is_wr    <= rx_sh[ADDR_W-1];
          reg_addr <= {rx_sh[ADDR_W-2:0], mosi_s};
          reg_re   <= ~rx_sh[ADDR_W-1];
        end
      end
      if (fall) begin
        if (!is_wr && cnt >= TX_FIRST && cnt < FULL_CNT) begin
          spi_miso <= tx_sh[DATA_W-1];
          tx_sh    <= {tx_sh[DATA_W-2:0], 1'b0};
        end else begin
          spi_miso <= 1'b0;
        end
      end
      if (stop && is_wr && cnt == FULL_CNT) begin
        reg_we    <= 1'b1;
        reg_wdata <= rx_sh;
      end
    end
  end

  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));
  a_r3_we_needs_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> $past(cnt == FULL_CNT) && !cs_q);
  a_r5_re_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_q |-> !spi_miso);
  a_r7_header_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && !start && cnt <= TX_FIRST - 1'b1) |-> !spi_miso);
  a_r7_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && is_wr) |-> !spi_miso);
endmodule

// File: tb/spi_regport_test.sv
`timescale 1ns/1ps
module spi_regport_test;
  localparam int H = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs = 1'b0, mosi = 1'b0;
  logic miso, we, re;
  logic [5:0]  addr;
  logic [23:0] wdata, rdata;

  spi_regport uut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs(cs), .spi_mosi(mosi),
    .spi_miso(miso), .reg_addr(addr), .reg_wdata(wdata), .reg_we(we),
    .reg_re(re), .reg_rdata(rdata));

  always #2 clk = ~clk;

  function automatic logic [23:0] seed(int i);
    return 24'(i * 32'h010203) ^ 24'h5A5A5A;
  endfunction

  logic [23:0] bank [64];
  logic [23:0] expm [64];
  int checks = 0, errors = 0;
  int we_cnt = 0, re_cnt = 0, idle_cyc = 0;
  logic [5:0]  last_waddr, last_raddr;
  logic [23:0] last_wdata;
  bit done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) bank[i] <= seed(i);
      rdata <= '0;
    end else begin
      if (re) rdata <= bank[addr];
      if (we) bank[addr] <= wdata;
    end
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (we) begin we_cnt++; last_waddr = addr; last_wdata = wdata; end
      if (re) begin re_cnt++; last_raddr = addr; end
      chk(!(we && re), "R3", "strobes together", {30'd0, we, re}, 32'd0);
      if (!cs) idle_cyc++; else idle_cyc = 0;
      if (idle_cyc > 3) chk(miso == 1'b0, "R7", "miso while idle", {31'd0, miso}, 32'd0);
    end
  end

  task automatic frame(int nbits, logic [31:0] tx, output logic [31:0] rx);
    rx = '0;
    @(negedge clk); #1;
    we_cnt = 0; re_cnt = 0;
    cs = 1'b1; mosi = tx[31];
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b1;
      rx = {rx[30:0], miso};
      repeat (H) @(negedge clk);
      sclk = 1'b0;
      mosi = (i < 31) ? tx[30-i] : 1'b0;
      repeat (H) @(negedge clk);
    end
    cs = 1'b0; mosi = 1'b0;
    repeat (3*H) @(negedge clk);
    #1;
  endtask

  task automatic do_write(int nbits, logic [5:0] a, logic [23:0] d, logic b24);
    logic [31:0] rx;
    frame(nbits, {1'b1, a, b24, d}, rx);
    if (nbits == 32) begin
      expm[a] = d;
      chk(we_cnt == 1, "R3", "write strobes", we_cnt, 1);
      chk(last_waddr == a, "R2", "write address", {26'd0, last_waddr}, {26'd0, a});
      chk(last_wdata == d, "R1", "write data", {8'd0, last_wdata}, {8'd0, d});
    end else begin
      chk(we_cnt == 0, "R4", "strobes on bad length", we_cnt, 0);
    end
    chk(re_cnt == 0, "R5", "read strobe on write", re_cnt, 0);
    chk(rx == 0, "R7", "miso during write", rx, 0);
  endtask

  task automatic do_read(int nbits, logic [5:0] a);
    logic [31:0] rx;
    frame(nbits, {1'b0, a, 1'b1, 24'hC3A5F0}, rx);
    chk(re_cnt == (nbits >= 7 ? 1 : 0), "R5", "read strobes", re_cnt, (nbits >= 7 ? 1 : 0));
    chk(we_cnt == 0, "R3", "write strobe on read", we_cnt, 0);
    if (nbits >= 7)
      chk(last_raddr == a, "R2", "read address", {26'd0, last_raddr}, {26'd0, a});
    if (nbits == 32) begin
      chk(rx[23:0] == expm[a], "R6", "read data", {8'd0, rx[23:0]}, {8'd0, expm[a]});
      chk(rx[31:24] == 8'd0, "R7", "read header bits", {24'd0, rx[31:24]}, 0);
    end
  endtask

  task automatic bank_scan(string req);
    int bad = 0;
    for (int i = 0; i < 64; i++) if (bank[i] !== expm[i]) bad++;
    chk(bad == 0, req, "bank contents mismatches", bad, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) expm[i] = seed(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(we == 0 && re == 0 && miso == 0, "R9", "reset outputs", {29'd0, we, re, miso}, 0);

    do_read(32, 6'd0);
    do_read(32, 6'd63);
    do_write(32, 6'd5, 24'h123456, 1'b0);
    do_read(32, 6'd5);
    do_write(32, 6'd63, 24'hFFFFFF, 1'b1);
    do_read(32, 6'd63);
    do_write(32, 6'd0, 24'h000000, 1'b0);
    do_read(32, 6'd0);
    do_write(32, 6'd42, 24'hA5C3E1, 1'b0);
    do_read(32, 6'd42);
    bank_scan("R3");

    do_write(31, 6'd9, 24'hDEAD01, 1'b0);
    bank_scan("R4");
    do_write(33, 6'd9, 24'hBEEF02, 1'b0);
    bank_scan("R4");
    do_read(32, 6'd9);
    do_read(5, 6'd17);
    do_read(7, 6'd18);

    @(negedge clk); #1;
    we_cnt = 0; re_cnt = 0;
    for (int i = 0; i < 40; i++) begin
      mosi = i[0]; sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
      repeat (H) @(negedge clk);
    end
    #1;
    chk(we_cnt == 0 && re_cnt == 0, "R8", "strobes with select low", we_cnt + re_cnt, 0);
    do_write(32, 6'd33, 24'h0F1E2D, 1'b0);
    do_read(32, 6'd33);
    bank_scan("R8");

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule